// File: doc/BRIEF.md
# Radio Power-Up Configuration Sequencer

This block takes an external 2.4 GHz radio transceiver from power-up to a configured state with no help from software. After reset it holds the radio in its low-power sleep step. It then moves the radio into configuration mode and waits there while the radio reloads its default registers. Finally it writes a fixed, ordered list of 16-bit configuration words over a serial data and clock pair. A timed low strobe on the chip-select line follows each word, and the radio latches the word on that strobe.

Two inputs shape the list. The role input picks the base list or the remote list. The 7-bit channel input becomes the low byte of the first word, which sets the receive channel: the carrier frequency is 2400 MHz plus the channel number. Each hold time is a count of clock cycles, worked out from the system clock frequency parameter and rounded up to whole cycles. When the last strobe ends, a done flag rises and stays high until the next reset.

Top module: `radio_cfg_seq`

## Requirements
- R1: While rst_n is low at a rising clock edge, the outputs after that edge are radio_pmode=0, radio_mode=1, radio_cs=0, ser_clk=0 and cfg_done=0 (the sleep step).
- R2: After rst_n is released, the sleep step (radio_pmode=0, radio_mode=1) lasts SLEEP_CYC = ceil(SLEEP_US*CLK_HZ/1e6) cycles. The count starts with the cycle in which rst_n goes high.
- R3: After the sleep step, radio_mode=0, radio_pmode=1 and radio_cs=1 are held for CFG_CYC = ceil(CFG_US*CLK_HZ/1e6) cycles before the first word starts. radio_mode stays 0 and radio_pmode stays 1 until the next reset.
- R4: Each word is sent MSB first as 16 bits. For each bit, ser_clk is low for SCLK_HALF cycles and then high for SCLK_HALF cycles. ser_data is valid at the rising edge of ser_clk and does not change while ser_clk is high. radio_cs stays 1 while a word is shifted.
- R5: After each word, radio_cs is 0 for exactly STB_CYC = ceil(STROBE_NS*CLK_HZ/1e9) cycles with ser_clk low, and then returns to 1.
- R6: The first word is {8'h80, 1'b0, channel}. A channel value of 0 is sent as 1, so the low byte always lies in 1..127.
- R7: With role_remote=0, the channel word is followed by 0x811B, 0x8503, 0x86B0, 0x8802, 0x8E01, 0x8FAA, 0x8902, 0x8AAA, 0x9401 and 0xAC18, in that order. 0x9401 selects the minimum PLL turn-on delay, which enables PLL pre-start.
- R8: With role_remote=1, the channel word is followed by the REM_N words of REM_TAIL, starting with the most significant 16 bits.
- R9: role_remote and channel are sampled in the last cycle of the configuration hold. Changes made after that do not alter the words sent.
- R10: cfg_done rises in the cycle in which radio_cs returns high after the last word's strobe. It stays high, with radio_cs=1 and ser_clk=0, until reset.
- R11: Asserting rst_n in the middle of the word writes restarts the whole sequence from the sleep step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| role_remote | input | 1 | 0 selects the base list, 1 selects the remote list |
| channel | input | 7 | Receive channel number (carrier frequency minus 2400 MHz) |
| radio_pmode | output | 1 | Radio power-mode control line |
| radio_mode | output | 1 | Radio mode control line |
| radio_cs | output | 1 | Radio chip-select line, pulsed low to latch a word |
| ser_clk | output | 1 | Serial clock for the configuration words |
| ser_data | output | 1 | Serial data, MSB first |
| cfg_done | output | 1 | High once every word has been written |

## Verification
The bench builds the block with CLK_HZ=2_100_000, SLEEP_US=20, CFG_US=30, STROBE_NS=5000, SCLK_HALF=2 and a four-word remote tail. With these values the 100 ms and 120 ms scale holds shrink to 42 and 63 cycles, so a complete sequence fits in about a thousand cycles. The bench can therefore run several full sequences, with both roles, the channel boundaries 0 and 127, a mid-sequence change of the inputs and a mid-sequence reset. The strobe works out to 10.5 cycles, which puts the round-up to 11 cycles within reach of the checks. The four-word tail shows that the remote list follows its parameter rather than the default.

// File: rtl/radio_cfg_pkg.sv
// Package: shared types and helpers for the radio configuration sequencer.
// Assumes: callers pass non-negative amounts and a positive divisor.
package radio_cfg_pkg;

    // Sequencer phases, in the order they occur after reset.
    typedef enum logic [2:0] {
        PH_SLEEP  = 3'd0,
        PH_CFG    = 3'd1,
        PH_SHIFT  = 3'd2,
        PH_STROBE = 3'd3,
        PH_DONE   = 3'd4
    } phase_e;

    // Number of fixed words that follow the channel word in the base list.
    localparam int unsigned BASE_TAIL_N = 10;

    // Upper byte of the channel word: write flag with register address 0.
    localparam logic [7:0] CHAN_WORD_HI = 8'h80;

    // Bits per configuration word.
    localparam int unsigned WORD_BITS = 16;

    // Integer division rounded up.
    function automatic longint ceil_div(input longint num, input longint den);
        return (num + den - 64'sd1) / den;
    endfunction

    // Base-role words after the channel word; position 1 is sent first.
    function automatic logic [15:0] base_tail_word(input int unsigned pos);
        case (pos)
            1:       return 16'h811B;
            2:       return 16'h8503;
            3:       return 16'h86B0;
            4:       return 16'h8802;
            5:       return 16'h8E01;
            6:       return 16'h8FAA;
            7:       return 16'h8902;
            8:       return 16'h8AAA;
            9:       return 16'h9401;
            10:      return 16'hAC18;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/rcs_phase_ctl.sv
// Module: phase controller of the sequencer.
// Walks sleep -> configuration hold -> (shift, strobe) per word -> done.
// One shared counter times the sleep, configuration and strobe holds.
// Latches role and channel on leaving the configuration hold.
// Assumes: shift_last pulses for one cycle at the end of each word.
module rcs_phase_ctl
    import radio_cfg_pkg::*;
#(
    parameter int unsigned SLEEP_CYC = 42,
    parameter int unsigned CFG_CYC   = 63,
    parameter int unsigned STB_CYC   = 11,
    parameter int unsigned IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             role_in,
    input  logic [6:0]       chan_in,
    input  logic             shift_last,
    input  logic [IDX_W-1:0] last_idx,
    output phase_e           phase,
    output logic [IDX_W-1:0] word_idx,
    output logic             role_q,
    output logic [6:0]       chan_q
);

    localparam int unsigned MAX_A = (SLEEP_CYC > CFG_CYC) ? SLEEP_CYC : CFG_CYC;
    localparam int unsigned MAX_CYC = (MAX_A > STB_CYC) ? MAX_A : STB_CYC;
    localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;

    // Phase sequencing, hold timing, word index and input latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_SLEEP;
            cnt      <= '0;
            word_idx <= '0;
            role_q   <= 1'b0;
            chan_q   <= 7'd1;
        end else begin
            case (phase)
                PH_SLEEP: begin
                    if (cnt == CNT_W'(SLEEP_CYC - 1)) begin
                        phase <= PH_CFG;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_CFG: begin
                    if (cnt == CNT_W'(CFG_CYC - 1)) begin
                        phase    <= PH_SHIFT;
                        cnt      <= '0;
                        word_idx <= '0;
                        role_q   <= role_in;
                        chan_q   <= (chan_in == 7'd0) ? 7'd1 : chan_in;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_SHIFT: begin
                    if (shift_last) begin
                        phase <= PH_STROBE;
                        cnt   <= '0;
                    end
                end
                PH_STROBE: begin
                    if (cnt == CNT_W'(STB_CYC - 1)) begin
                        cnt <= '0;
                        if (word_idx == last_idx) begin
                            phase <= PH_DONE;
                        end else begin
                            word_idx <= word_idx + 1'b1;
                            phase    <= PH_SHIFT;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_DONE;
                end
            endcase
        end
    end

endmodule

// File: rtl/rcs_word_sel.sv
// Module: configuration word selector.
// Returns the word at a list position for the latched role and channel.
// Position 0 is the channel word; later positions come from the base
// constants or from the remote tail parameter (most significant word first).
// Assumes: word_idx never exceeds last_idx.
module rcs_word_sel
    import radio_cfg_pkg::*;
#(
    parameter int unsigned            REM_N    = 3,
    parameter logic [REM_N*16-1:0]    REM_TAIL = {16'h811B, 16'h8503, 16'h8802},
    parameter int unsigned            IDX_W    = 4
) (
    input  logic             role_q,
    input  logic [6:0]       chan_q,
    input  logic [IDX_W-1:0] word_idx,
    output logic [15:0]      word,
    output logic [IDX_W-1:0] last_idx
);

    logic [15:0] rem_words [REM_N];
    logic [15:0] rem_pick;

    // Split the remote tail parameter into words, leftmost first.
    for (genvar g = 0; g < REM_N; g++) begin : g_rem
        assign rem_words[g] = REM_TAIL[(REM_N-1-g)*16 +: 16];
    end

    // Pick the remote word for the current position.
    always_comb begin
        rem_pick = 16'h0000;
        for (int k = 0; k < REM_N; k++) begin
            if (word_idx == IDX_W'(k + 1)) rem_pick = rem_words[k];
        end
    end

    // Build the word for the current position and role.
    always_comb begin
        if (word_idx == '0) begin
            word = {CHAN_WORD_HI, 1'b0, chan_q};
        end else if (role_q) begin
            word = rem_pick;
        end else begin
            word = base_tail_word(32'(word_idx));
        end
    end

    // Final list position for the latched role.
    assign last_idx = role_q ? IDX_W'(REM_N) : IDX_W'(BASE_TAIL_N);

endmodule

// File: rtl/rcs_shifter.sv
// Module: serial word shifter.
// While enabled, sends word MSB first: each bit is SCLK_HALF cycles with the
// clock low, then SCLK_HALF cycles with it high. last marks the final cycle.
// Assumes: en stays high for a whole word and word is stable meanwhile.
module rcs_shifter
    import radio_cfg_pkg::*;
#(
    parameter int unsigned SCLK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic [15:0] word,
    output logic        sclk,
    output logic        sdata,
    output logic        last
);

    localparam int unsigned PER_BIT = 2 * SCLK_HALF;
    localparam int unsigned SUB_W = (PER_BIT > 2) ? $clog2(PER_BIT) : 1;
    localparam int unsigned BIT_W = $clog2(WORD_BITS);

    logic [SUB_W-1:0] sub;
    logic [BIT_W-1:0] bit_i;

    // Advance the within-bit phase and the bit position while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sub   <= '0;
            bit_i <= '0;
        end else if (sub == SUB_W'(PER_BIT - 1)) begin
            sub   <= '0;
            bit_i <= bit_i + 1'b1;
        end else begin
            sub <= sub + 1'b1;
        end
    end

    assign sclk  = en && (sub >= SUB_W'(SCLK_HALF));
    assign sdata = en && word[BIT_W'(WORD_BITS - 1) - bit_i];
    assign last  = en && (bit_i == BIT_W'(WORD_BITS - 1)) && (sub == SUB_W'(PER_BIT - 1));

endmodule

// File: rtl/radio_cfg_seq.sv
// Module: radio power-up configuration sequencer (top).
// Drives the radio control lines through sleep and configuration holds,
// then writes the role-selected word list, each word closed by a CS strobe.
// Assumes: CLK_HZ is the frequency of clk; all hold times are rounded up.
module radio_cfg_seq
    import radio_cfg_pkg::*;
#(
    parameter int unsigned         CLK_HZ    = 100_000_000,
    parameter int unsigned         SLEEP_US  = 100_000,
    parameter int unsigned         CFG_US    = 120_000,
    parameter int unsigned         STROBE_NS = 5_000,
    parameter int unsigned         SCLK_HALF = 50,
    parameter int unsigned         REM_N     = 3,
    parameter logic [REM_N*16-1:0] REM_TAIL  = {16'h811B, 16'h8503, 16'h8802}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       role_remote,
    input  logic [6:0] channel,
    output logic       radio_pmode,
    output logic       radio_mode,
    output logic       radio_cs,
    output logic       ser_clk,
    output logic       ser_data,
    output logic       cfg_done
);

    localparam int unsigned SLEEP_CYC =
        int'(ceil_div(longint'(SLEEP_US) * longint'(CLK_HZ), 64'sd1_000_000));
    localparam int unsigned CFG_CYC =
        int'(ceil_div(longint'(CFG_US) * longint'(CLK_HZ), 64'sd1_000_000));
    localparam int unsigned STB_CYC =
        int'(ceil_div(longint'(STROBE_NS) * longint'(CLK_HZ), 64'sd1_000_000_000));
    localparam int unsigned MAX_IDX = (REM_N > BASE_TAIL_N) ? REM_N : BASE_TAIL_N;
    localparam int unsigned IDX_W = $clog2(MAX_IDX + 1);

    phase_e           phase;
    logic [IDX_W-1:0] word_idx;
    logic [IDX_W-1:0] last_idx;
    logic             role_q;
    logic [6:0]       chan_q;
    logic [15:0]      word;
    logic             shift_last;

    rcs_phase_ctl #(
        .SLEEP_CYC (SLEEP_CYC),
        .CFG_CYC   (CFG_CYC),
        .STB_CYC   (STB_CYC),
        .IDX_W     (IDX_W)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .role_in    (role_remote),
        .chan_in    (channel),
        .shift_last (shift_last),
        .last_idx   (last_idx),
        .phase      (phase),
        .word_idx   (word_idx),
        .role_q     (role_q),
        .chan_q     (chan_q)
    );

    rcs_word_sel #(
        .REM_N    (REM_N),
        .REM_TAIL (REM_TAIL),
        .IDX_W    (IDX_W)
    ) u_sel (
        .role_q   (role_q),
        .chan_q   (chan_q),
        .word_idx (word_idx),
        .word     (word),
        .last_idx (last_idx)
    );

    rcs_shifter #(
        .SCLK_HALF (SCLK_HALF)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (phase == PH_SHIFT),
        .word  (word),
        .sclk  (ser_clk),
        .sdata (ser_data),
        .last  (shift_last)
    );

    // Decode the radio control lines from the current phase.
    always_comb begin
        radio_pmode = (phase != PH_SLEEP);
        radio_mode  = (phase == PH_SLEEP);
        radio_cs    = (phase != PH_SLEEP) && (phase != PH_STROBE);
        cfg_done    = (phase == PH_DONE);
    end

endmodule

// File: rtl/rcs_chk.sv
// Module: assertion checker for radio_cfg_seq, bound to the top.
// Watches only the top ports; the strobe width is measured with a counter.
// Assumes: the same CLK_HZ and STROBE_NS as the bound instance.
module rcs_chk
    import radio_cfg_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned STROBE_NS = 5_000
) (
    input logic clk,
    input logic rst_n,
    input logic pmode,
    input logic mode,
    input logic cs,
    input logic sclk,
    input logic sdata,
    input logic done
);

    localparam int STB_CHK =
        int'(ceil_div(longint'(STROBE_NS) * longint'(CLK_HZ), 64'sd1_000_000_000));

    logic rst_was_low = 1'b0;
    int   low_run;

    // Remember whether reset was applied at the previous edge.
    always_ff @(posedge clk) rst_was_low <= !rst_n;

    // Count consecutive low-strobe cycles after the sleep step.
    always_ff @(posedge clk) begin
        if (!rst_n) low_run <= 0;
        else if (pmode && !cs) low_run <= low_run + 1;
        else low_run <= 0;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst_was_low |-> (mode && !pmode && !cs && !sclk && !done));

    // R4
    sdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdata));

    // R5
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pmode && !cs) |-> !sclk);

    // R5
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs) && pmode && $past(pmode)) |-> (low_run == STB_CHK));

    // R3
    cfg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode) |-> (pmode && cs && !sclk));

    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs && !sclk && pmode && !mode));

endmodule

bind radio_cfg_seq rcs_chk #(
    .CLK_HZ    (CLK_HZ),
    .STROBE_NS (STROBE_NS)
) u_rcs_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .pmode (radio_pmode),
    .mode  (radio_mode),
    .cs    (radio_cs),
    .sclk  (ser_clk),
    .sdata (ser_data),
    .done  (cfg_done)
);

// File: tb/tb_radio_cfg_seq.sv
// Directed bench for radio_cfg_seq: one task per scenario.
module tb_radio_cfg_seq;

    localparam int unsigned T_CLK_HZ = 2_100_000;
    localparam int unsigned T_SLEEP  = 42;   // ceil(20 us * 2.1 MHz)
    localparam int unsigned T_CFG    = 63;   // ceil(30 us * 2.1 MHz)
    localparam int unsigned T_STB    = 11;   // ceil(5 us * 2.1 MHz) = ceil(10.5)
    localparam int unsigned T_HALF   = 2;
    localparam int unsigned T_REM_N  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       role_remote = 1'b0;
    logic [6:0] channel = 7'd8;
    logic       radio_pmode, radio_mode, radio_cs, ser_clk, ser_data, cfg_done;

    int n_checks = 0;
    int n_fails  = 0;

    // Results of one captured sequence.
    logic [15:0] got_word [32];
    int got_bits [32];
    int got_high [32];
    int got_stb  [32];
    int n_words, sleep_cnt, pre_cnt, bad_cfg, done_nw, done_bad, done_early;

    radio_cfg_seq #(
        .CLK_HZ    (T_CLK_HZ),
        .SLEEP_US  (20),
        .CFG_US    (30),
        .STROBE_NS (5000),
        .SCLK_HALF (T_HALF),
        .REM_N     (T_REM_N),
        .REM_TAIL  ({16'h8110, 16'h8503, 16'h8802, 16'h9401})
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .role_remote (role_remote),
        .channel     (channel),
        .radio_pmode (radio_pmode),
        .radio_mode  (radio_mode),
        .radio_cs    (radio_cs),
        .ser_clk     (ser_clk),
        .ser_data    (ser_data),
        .cfg_done    (cfg_done)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input bit r, input logic [6:0] ch, input int i);
        if (i == 0) return {8'h80, 1'b0, (ch == 7'd0) ? 7'd1 : ch};
        if (!r) begin
            case (i)
                1: return 16'h811B;  2: return 16'h8503;  3: return 16'h86B0;
                4: return 16'h8802;  5: return 16'h8E01;  6: return 16'h8FAA;
                7: return 16'h8902;  8: return 16'h8AAA;  9: return 16'h9401;
                10: return 16'hAC18;
                default: return 16'h0000;
            endcase
        end
        case (i)
            1: return 16'h8110;  2: return 16'h8503;
            3: return 16'h8802;  4: return 16'h9401;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Release reset and record one sequence at each falling edge.
    // Optionally changes role/channel at sample change_at.
    task automatic capture(input int change_at, input bit new_role, input logic [6:0] new_ch);
        logic [15:0] cur = '0;
        int nbits = 0, hi = 0, stb = 0, after_done = 0;
        logic p_sclk = 1'b0, p_cs = 1'b0, p_pmode = 1'b0, seen_sclk = 1'b0;
        n_words = 0; sleep_cnt = 0; pre_cnt = 0; bad_cfg = 0;
        done_nw = -1; done_bad = 0; done_early = 0;
        rst_n = 1'b1;
        for (int t = 0; t < 5000; t++) begin
            if (t > 0) @(negedge clk);
            if (t == change_at) begin
                role_remote = new_role;
                channel = new_ch;
            end
            if (radio_mode && !radio_pmode) sleep_cnt++;
            if (p_pmode && (radio_mode || !radio_pmode)) bad_cfg++;
            if (radio_pmode && !seen_sclk) begin
                if (ser_clk) seen_sclk = 1'b1;
                else pre_cnt++;
            end
            if (ser_clk && !p_sclk) begin
                cur = {cur[14:0], ser_data};
                nbits++;
            end
            if (ser_clk) hi++;
            if (radio_pmode && !radio_cs) stb++;
            if (p_pmode && radio_pmode && radio_cs && !p_cs && n_words < 32) begin
                got_word[n_words] = cur;
                got_bits[n_words] = nbits;
                got_high[n_words] = hi;
                got_stb[n_words]  = stb;
                n_words++;
                nbits = 0; hi = 0; stb = 0;
            end
            if (cfg_done) begin
                if (done_nw < 0) done_nw = n_words;
                if (!radio_cs || ser_clk) done_bad++;
                after_done++;
                if (after_done > 20) break;
            end else if (done_nw >= 0) begin
                done_bad++;
            end
            p_sclk = ser_clk; p_cs = radio_cs; p_pmode = radio_pmode;
        end
    endtask

    // Compare one captured sequence against the expected list.
    task automatic verify(input bit r, input logic [6:0] ch, input string req_list);
        int exp_n = r ? 1 + T_REM_N : 11;
        check(sleep_cnt == T_SLEEP, "R2", "sleep cycles", sleep_cnt, T_SLEEP);
        check(pre_cnt == T_CFG + T_HALF, "R3", "cfg hold + first low half", pre_cnt, T_CFG + T_HALF);
        check(bad_cfg == 0, "R3", "mode lines left config mode", bad_cfg, 0);
        check(n_words == exp_n, req_list, "word count", n_words, exp_n);
        check(got_word[0] == exp_word(r, ch, 0), "R6", "channel word", got_word[0], exp_word(r, ch, 0));
        for (int i = 0; i < n_words && i < exp_n; i++) begin
            check(got_word[i] == exp_word(r, ch, i), req_list, $sformatf("word %0d", i),
                  got_word[i], exp_word(r, ch, i));
            check(got_bits[i] == 16 && got_high[i] == 16 * T_HALF, "R4",
                  $sformatf("bits/high cycles word %0d", i), got_high[i], 16 * T_HALF);
            check(got_stb[i] == T_STB, "R5", $sformatf("strobe width word %0d", i), got_stb[i], T_STB);
        end
        check(done_nw == exp_n, "R10", "done rises with last strobe end", done_nw, exp_n);
        check(done_bad == 0, "R10", "done held quiet", done_bad, 0);
    endtask

    task automatic t_reset_state();
        apply_reset();
        check(!radio_pmode && radio_mode && !radio_cs && !ser_clk && !cfg_done, "R1",
              "reset outputs {pmode,mode,cs,sclk,done}",
              {radio_pmode, radio_mode, radio_cs, ser_clk, cfg_done}, 5'b01000);
    endtask

    task automatic t_base_ch8();
        apply_reset();
        role_remote = 1'b0; channel = 7'd8;
        capture(-1, 1'b0, 7'd0);
        verify(1'b0, 7'd8, "R7");
    endtask

    task automatic t_remote_ch127();
        apply_reset();
        role_remote = 1'b1; channel = 7'd127;
        capture(-1, 1'b0, 7'd0);
        verify(1'b1, 7'd127, "R8");
    endtask

    task automatic t_chan_zero();
        apply_reset();
        role_remote = 1'b0; channel = 7'd0;
        capture(-1, 1'b0, 7'd0);
        check(got_word[0] == 16'h8001, "R6", "channel 0 sent as 1", got_word[0], 16'h8001);
        verify(1'b0, 7'd0, "R7");
    endtask

    task automatic t_change_midway();
        apply_reset();
        role_remote = 1'b0; channel = 7'd5;
        capture(150, 1'b1, 7'd99);
        verify(1'b0, 7'd5, "R9");
    endtask

    task automatic t_restart();
        apply_reset();
        role_remote = 1'b0; channel = 7'd17;
        rst_n = 1'b1;
        repeat (400) @(negedge clk);
        check(radio_pmode && !cfg_done, "R11", "mid-sequence before reset", radio_pmode, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!radio_pmode && radio_mode && !radio_cs && !ser_clk && !cfg_done, "R11",
              "restart outputs {pmode,mode,cs,sclk,done}",
              {radio_pmode, radio_mode, radio_cs, ser_clk, cfg_done}, 5'b01000);
        role_remote = 1'b1; channel = 7'd42;
        @(negedge clk);
        capture(-1, 1'b0, 7'd0);
        verify(1'b1, 7'd42, "R11");
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_base_ch8();
                t_remote_ch127();
                t_chan_zero();
                t_change_midway();
                t_restart();
            end
            begin
                repeat (50_000) @(posedge clk);
                check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule